// File: doc/BRIEF.md
# Asynchronous NAND Flash Bus Controller

This block drives one chip-select's worth of 8-bit asynchronous NAND flash from a simple host request port. The host asks for one of five operations (device reset, page read, page program, block erase, status read), supplying a row, a column and a byte count. Page data moves over valid/ready streams in both directions. The controller converts each request into a sequence of command, address and data cycles on the shared I/O byte lane. It marks each cycle type with the command-latch and address-latch strobes and uses the active-low write and read strobes to move every byte.

Once the device has been given an array operation, the controller watches the active-low ready/busy input. After a program, erase or reset it polls the device status byte until the ready bit is set, then returns the pass/fail and write-protect flags to the host. Leaving reset, it sends the device reset command on its own and keeps the host port closed until that completes. A host protect input drives the active-low write-protect pin. Strobe width, cycle length and the busy turnaround delay are parameters counted in system clocks. With a 4 ns clock, the defaults give a 12 ns strobe and a 24 ns cycle, which is above the 20 ns minimum. The cycle length must be at least the strobe width plus two.

Top module: `nand_async_ctrl`

## Requirements
- R1: After reset the first byte sent with CLE high is FFh. `reqReady` stays low until that reset has finished, including at least one status read with bit 6 set.
- R2: A command cycle has CLE high and ALE low, an address cycle has ALE high and CLE low, and a data cycle has both low. WE# and RE# are never low together. Each strobe pulse is low for exactly STROBE_CLKS clocks.
- R3: `nandDqOe` is low for the whole of every read cycle, starting from the clock before RE# falls.
- R4: A read (op 1) sends 00h, then col[7:0], {4'b0,col[11:8]}, row[7:0], row[15:8], {7'b0,row[16]}, then 30h. Here row = {block[10:0], page[5:0]}. After R/B# is high and TURN_CLKS more clocks have passed, it fetches `reqLen` bytes from consecutive columns.
- R5: A program (op 2) sends 80h, the same five address bytes, the `reqLen` write-stream bytes in order, then 10h.
- R6: An erase (op 3) sends 60h, the three row bytes in the order given in R4, then D0h.
- R7: No command other than 70h is sent while R/B# is low, and `reqReady` is low while R/B# is low.
- R8: A program, erase or reset (op 0) polls with 70h plus one read until status bit 6 is 1. It then pulses `doneValid` with `doneFail` = bit 0, `doneWpOff` = bit 7 and `doneStatus` = the whole byte.
- R9: A status request (op 4) sends 70h, reads one byte and reports it the same way as R8.
- R10: `nandWpN` is low whenever `wpEnable` is high and high otherwise. A program or erase under protection reports bit 7 clear.
- R11: While `rdValid` is high and `rdReady` is low, `rdData` holds and no further RE# pulse starts.
- R12: Column 2111 and row {11'd2047, 6'd63} are sent without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller accepts a request |
| reqOp | input | 3 | 0 reset, 1 read, 2 program, 3 erase, 4 status |
| reqRow | input | 17 | {block, page} row address |
| reqCol | input | 12 | Column (byte) address |
| reqLen | input | 12 | Bytes to transfer (1 or more) |
| wrValid | input | 1 | Program data valid |
| wrReady | output | 1 | Program byte taken |
| wrData | input | 8 | Program data byte |
| rdValid | output | 1 | Read data valid |
| rdReady | input | 1 | Host takes read byte |
| rdData | output | 8 | Read data byte |
| doneValid | output | 1 | One-clock completion pulse |
| doneFail | output | 1 | Status bit 0 |
| doneWpOff | output | 1 | Status bit 7 |
| doneStatus | output | 8 | Last status byte |
| wpEnable | input | 1 | Host write-protect request |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandWpN | output | 1 | Write protect, active low |
| nandDqOut | output | 8 | Byte lane driven to the device |
| nandDqOe | output | 1 | Byte lane output enable |
| nandDqIn | input | 8 | Byte lane from the device |
| nandRbN | input | 1 | Ready/busy, low while busy |

## Verification
The bench puts the device model busy at power-up and for a random time after each array command. This catches a controller that sends its first command into a busy device, or that opens the host port before the status poll sees ready. Reads stall `rdReady` at random points, so a design that lets RE# run ahead would lose or overwrite bytes. Directed cases use the highest column and row, which would expose a truncated upper address byte. Other directed cases use protected and failing program or erase, where swapped status bits would report the wrong flags. The model also measures every strobe width and flags any read pulse with the bus driven.

// File: rtl/nandc_pkg.sv
`timescale 1ns/1ps
package nandc_pkg;
  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_READ   = 3'd1,
    OP_PROG   = 3'd2,
    OP_ERASE  = 3'd3,
    OP_STATUS = 3'd4
  } hostOp_e;

  typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_WR, CY_RD} cyKind_e;

  typedef struct packed {
    logic    go;
    cyKind_e kind;
    logic [7:0] data;
  } busStrobe_t;

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_RD1   = 8'h00;
  localparam logic [7:0] CMD_RD2   = 8'h30;
  localparam logic [7:0] CMD_PG1   = 8'h80;
  localparam logic [7:0] CMD_PG2   = 8'h10;
  localparam logic [7:0] CMD_ER1   = 8'h60;
  localparam logic [7:0] CMD_ER2   = 8'hD0;
  localparam logic [7:0] CMD_STAT  = 8'h70;
endpackage

// File: rtl/nandc_bus.sv
`timescale 1ns/1ps
module nandc_bus
  import nandc_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int CYCLE_CLKS  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t cmdIn,
  output logic       busIdle,
  output logic       busDone,
  output logic [7:0] busRd,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       nandReN,
  output logic [7:0] nandDqOut,
  output logic       nandDqOe,
  input  logic [7:0] nandDqIn
);
  localparam int CW = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLE_CLKS - 1);
  localparam logic [CW-1:0] PWC  = CW'(STROBE_CLKS);

  logic          active;
  cyKind_e       kind;
  logic [7:0]    byteQ;
  logic [CW-1:0] cnt;
  logic          strobeOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      kind   <= CY_CMD;
      byteQ  <= '0;
      cnt    <= '0;
      busRd  <= '0;
    end else begin
      if (!active) begin
        if (cmdIn.go) begin
          active <= 1'b1;
          kind   <= cmdIn.kind;
          byteQ  <= cmdIn.data;
          cnt    <= '0;
        end
      end else begin
        if (kind == CY_RD && cnt == PWC) busRd <= nandDqIn;
        if (cnt == LAST) active <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  assign busIdle   = !active;
  assign busDone   = active && (cnt == LAST);
  assign strobeOn  = active && (cnt != '0) && (cnt <= PWC);
  assign nandWeN   = !(strobeOn && kind != CY_RD);
  assign nandReN   = !(strobeOn && kind == CY_RD);
  assign nandCle   = active && kind == CY_CMD;
  assign nandAle   = active && kind == CY_ADDR;
  assign nandDqOe  = active && kind != CY_RD;
  assign nandDqOut = byteQ;

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));
  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));
  a_r3_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe);
  a_r2_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> $stable(nandDqOut));
endmodule

// File: rtl/nandc_ctrl.sv
`timescale 1ns/1ps
module nandc_ctrl
  import nandc_pkg::*;
#(
  parameter int TURN_CLKS = 4,
  parameter int ROW_W     = 17,
  parameter int COL_W     = 12,
  parameter int LEN_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  hostOp_e          reqOp,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [7:0]       rdData,
  output logic             doneValid,
  output logic             doneFail,
  output logic             doneWpOff,
  output logic [7:0]       doneStatus,
  input  logic             rbN,
  output logic             ceN,
  output busStrobe_t       strobe,
  input  logic             busIdle,
  input  logic             busDone,
  input  logic [7:0]       busRd
);
  localparam int TW = $clog2(TURN_CLKS + 1) < 1 ? 1 : $clog2(TURN_CLKS + 1);
  localparam logic [TW-1:0] TURN_END = TW'(TURN_CLKS);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAITRB,
    S_TURN, S_RDATA, S_RHOLD, S_STCMD, S_STRD, S_DONE
  } state_e;

  state_e           state;
  hostOp_e          op;
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [LEN_W-1:0] lenQ, idx;
  logic [2:0]       aIdx;
  logic [TW-1:0]    tmr;
  logic [7:0]       statQ, rdQ;
  logic             initDone;
  logic [23:0]      rowPad;
  logic [15:0]      colPad;
  logic [7:0]       addrByte, cmd1Byte, cmd2Byte;
  logic             lastByte;

  assign rowPad   = 24'(rowQ);
  assign colPad   = 16'(colQ);
  assign lastByte = (idx == lenQ - 1'b1);

  always_comb begin
    case (aIdx)
      3'd0:    addrByte = colPad[7:0];
      3'd1:    addrByte = colPad[15:8];
      3'd2:    addrByte = rowPad[7:0];
      3'd3:    addrByte = rowPad[15:8];
      default: addrByte = rowPad[23:16];
    endcase
    case (op)
      OP_READ:   cmd1Byte = CMD_RD1;
      OP_PROG:   cmd1Byte = CMD_PG1;
      OP_ERASE:  cmd1Byte = CMD_ER1;
      OP_STATUS: cmd1Byte = CMD_STAT;
      default:   cmd1Byte = CMD_RESET;
    endcase
    case (op)
      OP_READ: cmd2Byte = CMD_RD2;
      OP_PROG: cmd2Byte = CMD_PG2;
      default: cmd2Byte = CMD_ER2;
    endcase
  end

  always_comb begin
    strobe = '{go: 1'b0, kind: CY_CMD, data: 8'h00};
    case (state)
      S_CMD1:  begin strobe.go = busIdle && (rbN || op == OP_STATUS); strobe.data = cmd1Byte; end
      S_ADDR:  begin strobe.go = busIdle; strobe.kind = CY_ADDR; strobe.data = addrByte; end
      S_WDATA: begin strobe.go = busIdle && wrValid; strobe.kind = CY_WR; strobe.data = wrData; end
      S_CMD2:  begin strobe.go = busIdle; strobe.data = cmd2Byte; end
      S_STCMD: begin strobe.go = busIdle; strobe.data = CMD_STAT; end
      S_RDATA, S_STRD: begin strobe.go = busIdle; strobe.kind = CY_RD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_CMD1; op <= OP_RESET;
      rowQ <= '0; colQ <= '0; lenQ <= '0; idx <= '0; aIdx <= '0;
      tmr <= '0; statQ <= '0; rdQ <= '0; initDone <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid && reqReady) begin
          op <= reqOp; rowQ <= reqRow; colQ <= reqCol; lenQ <= reqLen;
          state <= S_CMD1;
        end
        S_CMD1: if (busDone) begin
          case (op)
            OP_READ, OP_PROG: begin aIdx <= 3'd0; state <= S_ADDR; end
            OP_ERASE:         begin aIdx <= 3'd2; state <= S_ADDR; end
            OP_STATUS:        state <= S_STRD;
            default:          begin tmr <= '0; state <= S_WAITRB; end
          endcase
        end
        S_ADDR: if (busDone) begin
          if (aIdx == 3'd4) begin
            idx   <= '0;
            state <= (op == OP_PROG) ? S_WDATA : S_CMD2;
          end else aIdx <= aIdx + 1'b1;
        end
        S_WDATA: if (busDone) begin
          if (lastByte) state <= S_CMD2;
          else idx <= idx + 1'b1;
        end
        S_CMD2: if (busDone) begin tmr <= '0; state <= S_WAITRB; end
        S_WAITRB: begin
          if (tmr != TURN_END) tmr <= tmr + 1'b1;
          else if (op != OP_READ) state <= S_STCMD;
          else if (rbN) begin tmr <= '0; state <= S_TURN; end
        end
        S_TURN: begin
          if (tmr != TURN_END) tmr <= tmr + 1'b1;
          else begin idx <= '0; state <= S_RDATA; end
        end
        S_RDATA: if (busDone) begin rdQ <= busRd; state <= S_RHOLD; end
        S_RHOLD: if (rdReady) begin
          if (lastByte) state <= S_DONE;
          else begin idx <= idx + 1'b1; state <= S_RDATA; end
        end
        S_STCMD: if (busDone) state <= S_STRD;
        S_STRD: if (busDone) begin
          statQ <= busRd;
          if (op == OP_STATUS || busRd[6]) state <= S_DONE;
          else begin tmr <= '0; state <= S_WAITRB; end
        end
        default: begin initDone <= 1'b1; state <= S_IDLE; end
      endcase
    end
  end

  assign reqReady   = (state == S_IDLE) && initDone && rbN;
  assign wrReady    = (state == S_WDATA) && busIdle;
  assign rdValid    = (state == S_RHOLD);
  assign rdData     = rdQ;
  assign doneValid  = (state == S_DONE) && initDone;
  assign doneFail   = statQ[0];
  assign doneWpOff  = statQ[7];
  assign doneStatus = statQ;
  assign ceN        = (state == S_IDLE);

  a_r11_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
  a_r11_no_fetch_while_held: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |-> !strobe.go);
endmodule

// File: rtl/nand_async_ctrl.sv
`timescale 1ns/1ps
module nand_async_ctrl
  import nandc_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int CYCLE_CLKS  = 6,
  parameter int TURN_CLKS   = 4,
  parameter int PAGE_BITS   = 6,
  parameter int BLOCK_BITS  = 11,
  parameter int COL_BITS    = 12,
  parameter int LEN_BITS    = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [2:0]                    reqOp,
  input  logic [PAGE_BITS+BLOCK_BITS-1:0] reqRow,
  input  logic [COL_BITS-1:0]           reqCol,
  input  logic [LEN_BITS-1:0]           reqLen,
  input  logic                          wrValid,
  output logic                          wrReady,
  input  logic [7:0]                    wrData,
  output logic                          rdValid,
  input  logic                          rdReady,
  output logic [7:0]                    rdData,
  output logic                          doneValid,
  output logic                          doneFail,
  output logic                          doneWpOff,
  output logic [7:0]                    doneStatus,
  input  logic                          wpEnable,
  output logic                          nandCeN,
  output logic                          nandCle,
  output logic                          nandAle,
  output logic                          nandWeN,
  output logic                          nandReN,
  output logic                          nandWpN,
  output logic [7:0]                    nandDqOut,
  output logic                          nandDqOe,
  input  logic [7:0]                    nandDqIn,
  input  logic                          nandRbN
);
  localparam int ROW_W = PAGE_BITS + BLOCK_BITS;

  busStrobe_t strobe;
  logic       busIdle, busDone;
  logic [7:0] busRd;
  logic       cmdSeen;

  nandc_ctrl #(
    .TURN_CLKS(TURN_CLKS), .ROW_W(ROW_W), .COL_W(COL_BITS), .LEN_W(LEN_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(hostOp_e'(reqOp)),
    .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .doneValid(doneValid), .doneFail(doneFail), .doneWpOff(doneWpOff),
    .doneStatus(doneStatus), .rbN(nandRbN), .ceN(nandCeN),
    .strobe(strobe), .busIdle(busIdle), .busDone(busDone), .busRd(busRd)
  );

  nandc_bus #(.STROBE_CLKS(STROBE_CLKS), .CYCLE_CLKS(CYCLE_CLKS)) bus_i (
    .clk(clk), .rstN(rstN), .cmdIn(strobe),
    .busIdle(busIdle), .busDone(busDone), .busRd(busRd),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .nandDqIn(nandDqIn)
  );

  assign nandWpN = !wpEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdSeen <= 1'b0;
    else if (!nandWeN && nandCle) cmdSeen <= 1'b1;
  end

  a_r1_first_cmd_reset: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) && nandCle && !cmdSeen) |-> (nandDqOut == CMD_RESET));
  a_r7_no_cmd_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) && nandCle && (nandDqOut == CMD_RD1 || nandDqOut == CMD_PG1 ||
      nandDqOut == CMD_ER1 || nandDqOut == CMD_RESET)) |-> nandRbN);
endmodule

// File: tb/nand_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_async_ctrl_tb_top;
  import nandc_pkg::*;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic reqValid = 0, rdReady = 0, wrValid = 0, wpEnable = 0;
  logic [2:0] reqOp = 0;
  logic [16:0] reqRow = 0;
  logic [11:0] reqCol = 0, reqLen = 0;
  logic [7:0] wrData = 0;
  logic reqReady, wrReady, rdValid, doneValid, doneFail, doneWpOff;
  logic [7:0] rdData, doneStatus, nandDqOut;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandWpN, nandDqOe, nandRbN;
  logic [7:0] modelDq = 8'h00;

  nand_async_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .doneValid(doneValid), .doneFail(doneFail), .doneWpOff(doneWpOff),
    .doneStatus(doneStatus), .wpEnable(wpEnable),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandWpN(nandWpN),
    .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .nandDqIn(modelDq),
    .nandRbN(nandRbN)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dataAt(input logic [16:0] r, input logic [11:0] c);
    return r[7:0] ^ {r[16:13], c[11:8]} ^ c[7:0] ^ 8'hA5;
  endfunction
  function automatic bit failRow(input logic [16:0] r);
    return r[2:0] == 3'd5;
  endfunction
  function automatic logic [7:0] progByte(input int seed, input int i);
    return 8'(seed * 7 + i * 13 + 1);
  endfunction
  function automatic logic [7:0] expStatus(input bit wp, input bit fail);
    return {~wp, 1'b1, 5'b0, fail};
  endfunction

  // device model
  int busyCnt = 6;
  int weLow = 0, reLow = 0, pwErr = 0, oeErr = 0, busyCmdErr = 0, statusReads = 0;
  int firstCmd = -1, addrCnt = 0, progCnt = 0;
  logic prevWe = 1, prevRe = 1, lastFail = 0;
  logic [7:0] lastCmd = 8'hFF;
  logic [7:0] addrB [0:4];
  logic [7:0] progBuf [0:63];
  logic [16:0] curRow = 0, capRow = 0;
  logic [11:0] curCol = 0, capCol = 0;
  assign nandRbN = (busyCnt == 0);

  always @(negedge clk) begin
    if (busyCnt > 0) busyCnt--;
    if (!nandWeN) weLow++;
    if (!nandReN) begin reLow++; if (nandDqOe) oeErr++; end
    if (!prevWe && nandWeN) begin
      if (weLow != PW) pwErr++;
      weLow = 0;
      if (nandCle) begin
        if (firstCmd < 0) firstCmd = int'(nandDqOut);
        if (busyCnt > 0 && nandDqOut != 8'h70) busyCmdErr++;
        lastCmd = nandDqOut;
        case (nandDqOut)
          8'h00, 8'h60: addrCnt = 0;
          8'h80: begin addrCnt = 0; progCnt = 0; end
          8'h30, 8'h10: begin
            curRow = {addrB[4][0], addrB[3], addrB[2]};
            curCol = {addrB[1][3:0], addrB[0]};
            capRow = curRow; capCol = curCol;
            if (nandDqOut == 8'h10) lastFail = !nandWpN || failRow(curRow);
            busyCnt = 8 + int'($urandom % 24);
          end
          8'hD0: begin
            capRow = {addrB[2][0], addrB[1], addrB[0]};
            lastFail = !nandWpN || failRow(capRow);
            busyCnt = 8 + int'($urandom % 24);
          end
          8'hFF: begin lastFail = 0; busyCnt = 8 + int'($urandom % 24); end
          default: ;
        endcase
      end else if (nandAle) begin
        if (addrCnt < 5) addrB[addrCnt] = nandDqOut;
        addrCnt++;
      end else begin
        if (progCnt < 64) progBuf[progCnt] = nandDqOut;
        progCnt++;
      end
    end
    if (prevRe && !nandReN) begin
      if (lastCmd == 8'h70) begin
        modelDq = {nandWpN, busyCnt == 0, 5'b0, lastFail};
        statusReads++;
      end else modelDq = dataAt(curRow, curCol);
    end
    if (!prevRe && nandReN) begin
      if (reLow != PW) pwErr++;
      reLow = 0;
      if (lastCmd != 8'h70) curCol++;
    end
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  task automatic issue(input logic [2:0] op, input logic [16:0] row,
                       input logic [11:0] col, input logic [11:0] len);
    do @(negedge clk); while (!reqReady);
    reqOp = op; reqRow = row; reqCol = col; reqLen = len; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone;
    while (!doneValid) @(negedge clk);
  endtask

  bit expFail = 0;

  task automatic doRead(input logic [16:0] row, input logic [11:0] col, input int len);
    bit badData = 0, badHold = 0;
    issue(3'd1, row, col, 12'(len));
    for (int i = 0; i < len; i++) begin
      logic [7:0] held;
      while (!rdValid) @(negedge clk);
      if (rdData != dataAt(row, 12'(col + 12'(i)))) begin
        badData = 1;
        check(0, "R4", "read byte", rdData, dataAt(row, 12'(col + 12'(i))));
      end
      held = rdData;
      for (int s = 0; s < int'($urandom % 4); s++) begin
        @(negedge clk);
        if (!rdValid || rdData != held || !nandReN) badHold = 1;
      end
      rdReady = 1;
      @(negedge clk);
      rdReady = 0;
    end
    check(!badData, "R4", "read data stream", badData, 0);
    check(!badHold, "R11", "read byte held under stall", badHold, 0);
    waitDone();
    check(capRow == row && capCol == col, "R4", "read address",
          {capRow, capCol}, {row, col});
  endtask

  task automatic doProg(input logic [16:0] row, input logic [11:0] col, input int len);
    int seed = int'($urandom % 256);
    int bad = 0;
    issue(3'd2, row, col, 12'(len));
    for (int i = 0; i < len; i++) begin
      wrValid = 0;
      repeat (int'($urandom % 3)) @(negedge clk);
      wrValid = 1; wrData = progByte(seed, i);
      while (!wrReady) @(negedge clk);
      @(negedge clk);
    end
    wrValid = 0;
    waitDone();
    expFail = wpEnable || failRow(row);
    for (int i = 0; i < len; i++) if (progBuf[i] != progByte(seed, i)) bad++;
    check(progCnt == len && bad == 0, "R5", "program data count/mismatches",
          progCnt * 256 + bad, len * 256);
    check(capRow == row && capCol == col, "R5", "program address",
          {capRow, capCol}, {row, col});
    check(doneStatus == expStatus(wpEnable, expFail) && doneFail == expFail &&
          doneWpOff == !wpEnable, "R8", "program status",
          doneStatus, expStatus(wpEnable, expFail));
  endtask

  task automatic doErase(input logic [16:0] row);
    issue(3'd3, row, 12'h0, 12'h1);
    waitDone();
    expFail = wpEnable || failRow(row);
    check(capRow == row && addrCnt == 3, "R6", "erase row bytes",
          {capRow, 4'(addrCnt)}, {row, 4'd3});
    check(doneStatus == expStatus(wpEnable, expFail) && doneFail == expFail,
          "R8", "erase status", doneStatus, expStatus(wpEnable, expFail));
  endtask

  task automatic doStatus;
    issue(3'd4, 17'h0, 12'h0, 12'h1);
    waitDone();
    check(doneStatus == expStatus(wpEnable, expFail) && doneWpOff == !wpEnable,
          "R9", "status request", doneStatus, expStatus(wpEnable, expFail));
  endtask

  task automatic doReset;
    issue(3'd0, 17'h0, 12'h0, 12'h1);
    waitDone();
    expFail = 0;
    check(doneStatus == expStatus(wpEnable, 0), "R8", "reset status",
          doneStatus, expStatus(wpEnable, 0));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1/R2 reset state
    check(nandWeN && nandReN && !reqReady && !doneValid, "R1", "state in reset",
          {nandWeN, nandReN, reqReady, doneValid}, 4'b1100);
    rstN = 1;
    while (!reqReady) begin
      @(negedge clk);
      if (doneValid) check(0, "R1", "done pulse during init", 1, 0);
    end
    check(firstCmd == 8'hFF, "R1", "first command", firstCmd, 8'hFF);
    check(statusReads >= 1, "R1", "ready only after status poll", statusReads, 1);

    // R12 corners and R10 protection
    doRead({11'd2047, 6'd63}, 12'd2111, 1);
    doProg({11'd2047, 6'd63}, 12'd2100, 12);
    wpEnable = 1;
    @(negedge clk);
    check(nandWpN == 0, "R10", "write protect pin low", nandWpN, 0);
    doProg(17'h00100, 12'd0, 4);
    check(doneWpOff == 0 && doneFail == 1, "R10", "protected program flags",
          {doneWpOff, doneFail}, 2'b01);
    doErase(17'h00040);
    doStatus();
    wpEnable = 0;
    @(negedge clk);
    check(nandWpN == 1, "R10", "write protect pin released", nandWpN, 1);
    doErase(17'h00045);
    check(doneFail == 1, "R8", "failing erase flagged", doneFail, 1);
    doStatus();

    for (int n = 0; n < 40; n++) begin
      logic [16:0] row = 17'($urandom);
      logic [11:0] col = 12'($urandom % 2100);
      int len = 1 + int'($urandom % 12);
      if (n % 8 == 7) wpEnable = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: doRead(row, col, len);
        1: doProg(row, col, len);
        2: doErase(row);
        3: doStatus();
        default: if (n % 2 == 0) doReset(); else doRead(row, col, len);
      endcase
    end
    repeat (20) @(negedge clk);
    check(pwErr == 0, "R2", "strobe widths off", pwErr, 0);
    check(oeErr == 0, "R3", "bus driven during read strobe", oeErr, 0);
    check(busyCmdErr == 0, "R7", "command sent while busy", busyCmdErr, 0);
    finishRun();
  end
endmodule